// File: doc/BRIEF.md
# Multi-port cell receive interface

This block hands received fixed-length cells from several per-port receive queues to an attached cell-layer device over one shared byte-wide bus. The bus runs on an externally supplied, free-running receive clock. Each port tells the device through its own cell-available line that a whole cell is ready to read. The device requests bytes by pulling low that port's enable line.

On every clock edge the block selects one port from the enables and, if that port holds data, moves one byte. Each port keeps its own byte position, so a cell can be stalled or interleaved with other ports and resume where it stopped. The block marks the first byte of each cell, adds odd parity to the bus and produces an output-enable for the data and start-of-cell outputs. A diagnostic input lets those outputs float while no enable is active.

On the queue side each port acts as a stream sink. The queue presents its head byte at all times (valid is implied by a non-zero complete-cell count or a cell already under way). The block's pop output is the ready/accept strobe. A byte counts as consumed on the clock edge where its pop is high, and the queue must show the next byte by the following cycle. Back-pressure from the device is applied only through the enables: an enable held high never pops anything.

Top module: `cell_rx_mux`

## Requirements
- R1: The block has NPORTS ports (default 4) that share one DATA_W-bit (default 8) data bus. Each port has its own active-low enable input `rx_en_n[p]`, its own cell-available output `rx_clav[p]` and its own pop output `fifo_pop[p]`.
- R2: `rx_clav[p]` is high in a cycle exactly when port p's complete-cell count exceeds 1 (if a cell of p is part-way through transfer) or 0 (otherwise). As a result it drops in the cycle after the first byte of the port's last waiting cell is popped.
- R3: The selected port is the lowest-numbered port whose enable is low. At most one `fifo_pop` bit is high in any cycle, and only the selected port's bit may be high.
- R4: `fifo_pop[p]` is high, and `rx_data` equals port p's head byte `fifo_byte[p*DATA_W +: DATA_W]`, exactly when p is selected and has data. A port has data when it is mid-cell or its cell count is non-zero. In every other cycle `rx_data` is 0 and nothing is popped.
- R5: A cell is CELL_LEN bytes (default 53). `rx_soc` is high in the same cycle as the pop of byte 0 of a cell and at no other time. Each port's byte position survives stalls and transfers on other ports.
- R6: `rx_par` gives odd parity over `rx_data`: the count of ones in `rx_data` together with `rx_par` is odd. Idle data 0 therefore gives `rx_par` = 1.
- R7: `rx_drive` is low when `diag_float` is high and every enable is high, and is high otherwise.
- R8: During and after reset every port's byte position is 0, so the first byte popped from each port after reset carries `rx_soc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Active-low reset |
| diag_float | input | 1 | Let data and start-of-cell float while no enable is low |
| rx_en_n | input | NPORTS | Active-low per-port read enables |
| fifo_cells | input | NPORTS*CNT_W | Per-port count of complete cells queued |
| fifo_byte | input | NPORTS*DATA_W | Per-port queue head byte |
| fifo_pop | output | NPORTS | Per-port byte accept strobe |
| rx_clav | output | NPORTS | Per-port cell available |
| rx_data | output | DATA_W | Shared data bus |
| rx_soc | output | 1 | Start of cell, with byte 0 |
| rx_par | output | 1 | Odd parity over rx_data |
| rx_drive | output | 1 | Output enable for rx_data and rx_soc |

## Verification
Pop, data, start-of-cell, parity, drive and cell-available are all combinational in the current enables, queue counts and stored byte positions, so each is due in the same cycle as the input that causes it. A change in byte position becomes visible one edge after a pop. The bench drives inputs on the falling edge, compares every output against its behavioural model one nanosecond later, and advances the model's positions and counts only at the next rising edge. A dropped cell-available is therefore expected exactly one cycle after the pop of a cell's first byte.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/cell_rx_pick.sv
module cell_rx_pick #(
  parameter int NPORTS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [NPORTS-1:0] en_n,
  output logic [SEL_W-1:0]  sel,
  output logic              any_low
);
  always_comb begin
    sel     = '0;
    any_low = 1'b0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (!en_n[i]) begin
        sel     = SEL_W'(i);
        any_low = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_rx_lane.sv
module cell_rx_lane #(
  parameter int CELL_LEN = 53,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic [CNT_W-1:0] cells,
  output logic             at_start,
  output logic             has_byte,
  output logic             clav
);
  localparam int POS_W = $clog2(CELL_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(CELL_LEN - 1);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (pop)
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

  assign at_start = (pos == '0);
  assign has_byte = !at_start || (cells != '0);
  assign clav     = cells > CNT_W'(!at_start);
endmodule

// File: rtl/cell_rx_mux.sv
module cell_rx_mux #(
  parameter int NPORTS   = 4,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int CELL_LEN = 53
) (
  input  logic                     rx_clk,
  input  logic                     rst_n,
  input  logic                     diag_float,
  input  logic [NPORTS-1:0]        rx_en_n,
  input  logic [NPORTS*CNT_W-1:0]  fifo_cells,
  input  logic [NPORTS*DATA_W-1:0] fifo_byte,
  output logic [NPORTS-1:0]        fifo_pop,
  output logic [NPORTS-1:0]        rx_clav,
  output logic [DATA_W-1:0]        rx_data,
  output logic                     rx_soc,
  output logic                     rx_par,
  output logic                     rx_drive
);
  localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [SEL_W-1:0]  sel;
  logic              any_low;
  logic [NPORTS-1:0] at_start, has_byte;
  logic              xfer;

  cell_rx_pick #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_pick (
    .en_n(rx_en_n), .sel(sel), .any_low(any_low)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_lane
    assign fifo_pop[g] = xfer && (sel == SEL_W'(g));
    cell_rx_lane #(.CELL_LEN(CELL_LEN), .CNT_W(CNT_W)) u_lane (
      .clk(rx_clk), .rst_n(rst_n), .pop(fifo_pop[g]),
      .cells(fifo_cells[g*CNT_W +: CNT_W]),
      .at_start(at_start[g]), .has_byte(has_byte[g]), .clav(rx_clav[g])
    );
  end

  assign xfer     = any_low && has_byte[sel];
  assign rx_data  = xfer ? fifo_byte[sel*DATA_W +: DATA_W] : '0;
  assign rx_soc   = xfer && at_start[sel];
  assign rx_par   = ~(^rx_data);
  assign rx_drive = !(diag_float && (&rx_en_n));
endmodule

// File: rtl/cell_rx_chk.sv
module cell_rx_chk #(
  parameter int NPORTS = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic                     rx_clk,
  input logic                     rst_n,
  input logic                     diag_float,
  input logic [NPORTS-1:0]        rx_en_n,
  input logic [NPORTS*CNT_W-1:0]  fifo_cells,
  input logic [NPORTS-1:0]        fifo_pop,
  input logic [NPORTS-1:0]        rx_clav,
  input logic [DATA_W-1:0]        rx_data,
  input logic                     rx_soc,
  input logic                     rx_drive
);
  p_one_pop_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
    $onehot0(fifo_pop));

  p_soc_pop_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_soc |-> (|fifo_pop));

  p_idle_bus_r4: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !(|fifo_pop) |-> (rx_data == '0) && !rx_soc);

  p_float_r7: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (diag_float && (&rx_en_n)) |-> !rx_drive);

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    localparam logic [NPORTS-1:0] LOWER = NPORTS'((1 << g) - 1);
    p_pop_en_r4: assert property (@(posedge rx_clk) disable iff (!rst_n)
      fifo_pop[g] |-> !rx_en_n[g]);
    p_pop_prio_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
      fifo_pop[g] |-> (&(rx_en_n | ~LOWER)));
    p_clav_cells_r2: assert property (@(posedge rx_clk) disable iff (!rst_n)
      rx_clav[g] |-> (fifo_cells[g*CNT_W +: CNT_W] != '0));
  end
endmodule

bind cell_rx_mux cell_rx_chk #(.NPORTS(NPORTS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .rx_clk(rx_clk), .rst_n(rst_n), .diag_float(diag_float), .rx_en_n(rx_en_n),
  .fifo_cells(fifo_cells), .fifo_pop(fifo_pop), .rx_clav(rx_clav),
  .rx_data(rx_data), .rx_soc(rx_soc), .rx_drive(rx_drive)
);

// File: tb/test_cell_rx_mux.sv
module test_cell_rx_mux;
  localparam int NP = 4, DW = 8, CW = 4, CL = 53;

  logic          rx_clk = 0, rst_n = 0, diag_float = 0;
  logic [NP-1:0] rx_en_n = '1;
  logic [NP*CW-1:0] fifo_cells = '0;
  logic [NP*DW-1:0] fifo_byte = '0;
  logic [NP-1:0] fifo_pop, rx_clav;
  logic [DW-1:0] rx_data;
  logic          rx_soc, rx_par, rx_drive;

  int checks = 0, errors = 0;
  int cnt[NP], pos[NP], cid[NP];
  bit exp_x; int exp_s;

  always #4 rx_clk = ~rx_clk;

  cell_rx_mux #(.NPORTS(NP), .DATA_W(DW), .CNT_W(CW), .CELL_LEN(CL)) i_cell_rx_mux (
    .rx_clk(rx_clk), .rst_n(rst_n), .diag_float(diag_float), .rx_en_n(rx_en_n),
    .fifo_cells(fifo_cells), .fifo_byte(fifo_byte), .fifo_pop(fifo_pop),
    .rx_clav(rx_clav), .rx_data(rx_data), .rx_soc(rx_soc), .rx_par(rx_par),
    .rx_drive(rx_drive)
  );

  function automatic logic [7:0] head(int p);
    return 8'((p * 61 + cid[p] * 17 + pos[p] * 3 + 5) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic [NP-1:0] en, bit flt);
    rx_en_n = en;
    diag_float = flt;
    for (int p = 0; p < NP; p++) begin
      fifo_cells[p*CW +: CW] = CW'(cnt[p]);
      fifo_byte[p*DW +: DW] = head(p);
    end
  endtask

  task automatic compare();
    int e_data; int e_soc;
    exp_s = -1;
    for (int p = NP - 1; p >= 0; p--) if (!rx_en_n[p]) exp_s = p;
    exp_x = (exp_s >= 0) && ((pos[exp_s] != 0) || (cnt[exp_s] > 0));
    e_data = exp_x ? int'(head(exp_s)) : 0;
    e_soc = (exp_x && pos[exp_s] == 0) ? 1 : 0;
    for (int p = 0; p < NP; p++) begin
      chk("R2 clav", int'(rx_clav[p]), (cnt[p] > ((pos[p] != 0) ? 1 : 0)) ? 1 : 0);
      chk("R3 pop", int'(fifo_pop[p]), (exp_x && exp_s == p) ? 1 : 0);
    end
    chk("R4 data", int'(rx_data), e_data);
    chk("R5 soc", int'(rx_soc), e_soc);
    chk("R6 parity", int'(rx_par), ($countones(e_data) % 2 == 0) ? 1 : 0);
    chk("R7 drive", int'(rx_drive), (diag_float && (&rx_en_n)) ? 0 : 1);
  endtask

  task automatic step(logic [NP-1:0] en, bit flt, logic [NP-1:0] arrive);
    @(negedge rx_clk);
    drive(en, flt);
    #1;
    compare();
    @(posedge rx_clk);
    if (exp_x) begin
      pos[exp_s]++;
      if (pos[exp_s] == CL) begin
        pos[exp_s] = 0; cnt[exp_s]--; cid[exp_s]++;
      end
    end
    for (int p = 0; p < NP; p++) if (arrive[p] && cnt[p] < 15) cnt[p]++;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin cnt[p] = 0; pos[p] = 0; cid[p] = 0; end
    cnt[1] = 1;
    drive('1, 0);
    // R8: reset state, enables high
    repeat (3) begin
      @(negedge rx_clk); #1;
      chk("R8 soc", int'(rx_soc), 0);
      chk("R8 data", int'(rx_data), 0);
      chk("R8 clav", int'(rx_clav), 2);
      checks++;
    end
    rst_n = 1;
    // R1 R5: one full cell from port 1, continuous enable; clav drops after byte 0
    for (int i = 0; i < CL + 3; i++) step(4'b1101, 0, '0);
    // R3: ports 0 and 2 both ready, all enables low, port 0 wins
    cnt[0] = 1; cnt[2] = 2;
    for (int i = 0; i < CL + 10; i++) step(4'b0000, 0, '0);
    // R5: stalled and interleaved cell on port 2, float on idle (R7)
    for (int i = 0; i < 200; i++)
      step((i % 3 == 0) ? 4'b1111 : ((i % 2 == 0) ? 4'b1011 : 4'b1110), 1, (i == 50) ? 4'b0001 : '0);
    // mixed traffic
    for (int i = 0; i < 6000; i++)
      step(NP'($urandom), ($urandom % 4) == 0,
           (($urandom % 30) == 0) ? NP'($urandom) : '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule